// File: doc/BRIEF.md
# Byte-Lane SRAM Access Port

This block is a clock-synchronous model of the host-facing access port of a nonvolatile SRAM. On each rising clock edge it samples the active-low select, output-enable, write-enable, two byte-lane enables and an active-low store-busy line. From these it decides whether the cycle is a 16-bit word read, a 16-bit word write, or no access. Each byte lane is gated on its own, so a single access can touch the high byte, the low byte or both.

An inhibit input from the store/recall engine blocks all accesses while a nonvolatile transfer is running. A low level on the busy line blocks them in the same way. Read data is registered and appears one cycle after the read is sampled, together with a per-lane valid flag that stands in for the output drivers. Every write that changes at least one lane produces a one-cycle `write_accepted` pulse. The store/recall engine uses this pulse to decide whether a later store is needed.

The array depth is set by the parameter `ADDR_W`, with a default of 1024 words. The array contents are not cleared by reset.

Top module: `nvram_host_port`

## Requirements
- R1: A read is sampled when `sel_n`=0, `oe_n`=0, `we_n`=1, `busy_n`=1 and `inhibit`=0. On the next cycle `rdata` holds the stored word for the enabled lanes.
- R2: A write is sampled when `sel_n`=0, `we_n`=0, `busy_n`=1 and `inhibit`=0, whatever the level of `oe_n`.
- R3: On a write, `lane_lo_n`=0 updates bits 7:0 and `lane_hi_n`=0 updates bits 15:8. A lane whose enable is high keeps its old contents.
- R4: On a read, `rvalid_hi` and `rvalid_lo` are 1 in the next cycle only for enabled lanes. A lane that is not valid reads as 0 on `rdata`.
- R5: A write sampled with `oe_n`=0 gives no valid read flag in the next cycle.
- R6: While the read controls are held steady, each new address is read back one cycle later, with no control transition needed.
- R7: With `sel_n`=1, or with both lane enables high, there is no read and no write: both flags stay 0 and the array is unchanged.
- R8: While `busy_n`=0, reads and writes are refused. The flags stay 0 and the array is unchanged.
- R9: While `inhibit`=1, reads and writes are refused. The flags stay 0 and the array is unchanged.
- R10: `write_accepted` is high for exactly the one cycle after each write that updates at least one lane. It stays low after a write with both lanes disabled.
- R11: Synchronous reset clears `rdata`, `rvalid_hi`, `rvalid_lo` and `write_accepted` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lane_hi_n | input | 1 | High byte lane enable, active low |
| lane_lo_n | input | 1 | Low byte lane enable, active low |
| busy_n | input | 1 | Store-busy line; low blocks access |
| inhibit | input | 1 | Store/recall engine blocks access |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, zero in lanes that are not valid |
| rvalid_hi | output | 1 | High lane of rdata valid |
| rvalid_lo | output | 1 | Low lane of rdata valid |
| write_accepted | output | 1 | One-cycle pulse after an accepted write |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each sampling edge. They also assume that reset is held high from time zero for at least one edge. The bench changes inputs only on falling edges and starts with reset asserted, so both assumptions hold. The address is kept inside the array depth, so no out-of-range access occurs.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [LANES-1:0] lanes;
    } access_t;

    function automatic access_t classify(
        input logic sel_n, input logic oe_n, input logic we_n,
        input logic busy_n, input logic inhibit, input logic [LANES-1:0] lane_on);
        access_t a;
        logic open_port;
        open_port = !sel_n && busy_n && !inhibit && (|lane_on);
        a.rd    = open_port && !oe_n && we_n;
        a.wr    = open_port && !we_n;
        a.lanes = lane_on;
        return a;
    endfunction
endpackage

// File: rtl/port_decode.sv
module port_decode
    import nvram_port_pkg::*;
(
    input  logic    sel_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    lane_hi_n,
    input  logic    lane_lo_n,
    input  logic    busy_n,
    input  logic    inhibit,
    output access_t acc
);
    logic [LANES-1:0] lane_on;
    assign lane_on = {~lane_hi_n, ~lane_lo_n};

    always_comb begin
        acc = classify(sel_n, oe_n, we_n, busy_n, inhibit, lane_on);
    end
endmodule

// File: rtl/lane_store.sv
module lane_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wd,
    output logic [LANE_W-1:0] rd,
    output logic              valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd    <= '0;
            valid <= 1'b0;
        end else begin
            valid <= rd_en;
            rd    <= rd_en ? cells[addr] : '0;
        end
    end
endmodule

// File: rtl/ack_stage.sv
module ack_stage
    import nvram_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    output logic    pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= acc.wr && (|acc.lanes);
        end
    end
endmodule

// File: rtl/nvram_host_port.sv
module nvram_host_port
    import nvram_port_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lane_hi_n,
    input  logic              lane_lo_n,
    input  logic              busy_n,
    input  logic              inhibit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid_hi,
    output logic              rvalid_lo,
    output logic              write_accepted
);
    access_t          acc;
    logic [LANES-1:0] lane_valid;

    port_decode u_dec (
        .sel_n     (sel_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .lane_hi_n (lane_hi_n),
        .lane_lo_n (lane_lo_n),
        .busy_n    (busy_n),
        .inhibit   (inhibit),
        .acc       (acc)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .wr_en (acc.wr && acc.lanes[g]),
            .rd_en (acc.rd && acc.lanes[g]),
            .addr  (addr),
            .wd    (wdata[g*LANE_W +: LANE_W]),
            .rd    (rdata[g*LANE_W +: LANE_W]),
            .valid (lane_valid[g])
        );
    end

    assign rvalid_hi = lane_valid[LANES-1];
    assign rvalid_lo = lane_valid[0];

    ack_stage u_ack (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .pulse (write_accepted)
    );
endmodule

// File: rtl/nvram_host_port_chk.sv
module nvram_host_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        sel_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        lane_hi_n,
    input logic        lane_lo_n,
    input logic        busy_n,
    input logic        inhibit,
    input logic [15:0] rdata,
    input logic        rvalid_hi,
    input logic        rvalid_lo,
    input logic        write_accepted
);
    assert_rd_hi_cause_R1: assert property (@(posedge clk) disable iff (rst)
        rvalid_hi |-> $past(!sel_n && !oe_n && we_n && busy_n && !inhibit && !lane_hi_n));

    assert_rd_lo_cause_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid_lo |-> $past(!sel_n && !oe_n && we_n && busy_n && !inhibit && !lane_lo_n));

    assert_wr_cause_R10: assert property (@(posedge clk) disable iff (rst)
        write_accepted |-> $past(!sel_n && !we_n && busy_n && !inhibit && !(lane_hi_n && lane_lo_n)));

    assert_busy_block_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!busy_n) |-> !(write_accepted || rvalid_hi || rvalid_lo));

    assert_inhibit_block_R9: assert property (@(posedge clk) disable iff (rst)
        $past(inhibit) |-> !(write_accepted || rvalid_hi || rvalid_lo));

    assert_write_no_out_R5: assert property (@(posedge clk) disable iff (rst)
        write_accepted |-> !(rvalid_hi || rvalid_lo));

    assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (!rvalid_hi |-> rdata[15:8] == 8'h00) and (!rvalid_lo |-> rdata[7:0] == 8'h00));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> !(write_accepted || rvalid_hi || rvalid_lo));
endmodule

bind nvram_host_port nvram_host_port_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sel_n          (sel_n),
    .oe_n           (oe_n),
    .we_n           (we_n),
    .lane_hi_n      (lane_hi_n),
    .lane_lo_n      (lane_lo_n),
    .busy_n         (busy_n),
    .inhibit        (inhibit),
    .rdata          (rdata),
    .rvalid_hi      (rvalid_hi),
    .rvalid_lo      (rvalid_lo),
    .write_accepted (write_accepted)
);

// File: tb/tb_nvram_host_port.sv
module tb_nvram_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    // ctl = {sel_n, oe_n, we_n, lane_hi_n, lane_lo_n, busy_n, inhibit}
    // exp = {rvalid_hi, rvalid_lo, write_accepted}, seen one cycle later
    typedef struct packed {
        logic [6:0]    ctl;
        logic [AW-1:0] a;
        logic [15:0]   wd;
        logic [15:0]   erd;
        logic [2:0]    exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{7'b0100010, 10'd5,    16'hA1B2, 16'h0000, 3'b001, 4'd2},  // R2 write both lanes
        '{7'b0000010, 10'd6,    16'hC3D4, 16'h0000, 3'b001, 4'd5},  // R5 write, oe low
        '{7'b0010010, 10'd5,    16'h0000, 16'hA1B2, 3'b110, 4'd1},  // R1 read
        '{7'b0010010, 10'd6,    16'h0000, 16'hC3D4, 3'b110, 4'd6},  // R6 address follow
        '{7'b0101010, 10'd5,    16'hFFEE, 16'h0000, 3'b001, 4'd3},  // R3 low lane only
        '{7'b0100110, 10'd6,    16'h1122, 16'h0000, 3'b001, 4'd3},  // R3 high lane only
        '{7'b0010010, 10'd5,    16'h0000, 16'hA1EE, 3'b110, 4'd3},  // R3 merge check
        '{7'b0010110, 10'd6,    16'h0000, 16'h1100, 3'b100, 4'd4},  // R4 high read
        '{7'b0011010, 10'd6,    16'h0000, 16'h00D4, 3'b010, 4'd4},  // R4 low read
        '{7'b0100000, 10'd5,    16'h0000, 16'h0000, 3'b000, 4'd8},  // R8 write busy
        '{7'b0010000, 10'd5,    16'h0000, 16'h0000, 3'b000, 4'd8},  // R8 read busy
        '{7'b0100011, 10'd6,    16'h0000, 16'h0000, 3'b000, 4'd9},  // R9 write inhibit
        '{7'b0010011, 10'd6,    16'h0000, 16'h0000, 3'b000, 4'd9},  // R9 read inhibit
        '{7'b1100010, 10'd5,    16'h0000, 16'h0000, 3'b000, 4'd7},  // R7 write deselected
        '{7'b0101110, 10'd6,    16'h0000, 16'h0000, 3'b000, 4'd10}, // R10 write, no lanes
        '{7'b0011110, 10'd5,    16'h0000, 16'h0000, 3'b000, 4'd7},  // R7 read, no lanes
        '{7'b1010010, 10'd5,    16'h0000, 16'h0000, 3'b000, 4'd7},  // R7 read deselected
        '{7'b0010010, 10'd5,    16'h0000, 16'hA1EE, 3'b110, 4'd8},  // R8 R7 unchanged
        '{7'b0010010, 10'd6,    16'h0000, 16'h11D4, 3'b110, 4'd9},  // R9 R10 unchanged
        '{7'b0100010, 10'd1023, 16'h5A5A, 16'h0000, 3'b001, 4'd2},  // R2 top address
        '{7'b0010010, 10'd1023, 16'h0000, 16'h5A5A, 3'b110, 4'd6},  // R6 top address
        '{7'b1111110, 10'd0,    16'h0000, 16'h0000, 3'b000, 4'd10}  // R10 pulse ended
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic lane_hi_n = 1'b1, lane_lo_n = 1'b1, busy_n = 1'b1, inhibit = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          rvalid_hi, rvalid_lo, write_accepted;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvram_host_port #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
        .lane_hi_n(lane_hi_n), .lane_lo_n(lane_lo_n), .busy_n(busy_n),
        .inhibit(inhibit), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rvalid_hi(rvalid_hi), .rvalid_lo(rvalid_lo), .write_accepted(write_accepted)
    );

    task automatic check(input int req, input logic [15:0] erd, input logic [2:0] eflag);
        checks++;
        if (rdata !== erd || {rvalid_hi, rvalid_lo, write_accepted} !== eflag) begin
            errors++;
            $display("FAIL R%0d: rdata=%h flags=%b expected rdata=%h flags=%b",
                     req, rdata, {rvalid_hi, rvalid_lo, write_accepted}, erd, eflag);
        end
    endtask

    task automatic apply(input logic [6:0] c, input logic [AW-1:0] a, input logic [15:0] d);
        {sel_n, oe_n, we_n, lane_hi_n, lane_lo_n, busy_n, inhibit} = c;
        addr  = a;
        wdata = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(11, 16'h0000, 3'b000);  // R11 state while reset held
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].ctl, VEC[i].a, VEC[i].wd);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].erd, VEC[i].exp);
        end
        // R11: reset during a read clears outputs at the next edge
        apply(7'b0010010, 10'd5, 16'h0000);
        @(negedge clk);
        check(1, 16'hA1EE, 3'b110);
        rst = 1'b1;
        @(negedge clk);
        check(11, 16'h0000, 3'b000);
        rst = 1'b0;
        // R10: two consecutive writes give two pulses
        apply(7'b0100010, 10'd7, 16'h0F0F);
        @(negedge clk);
        check(10, 16'h0000, 3'b001);
        apply(7'b0100010, 10'd8, 16'hF0F0);
        @(negedge clk);
        check(10, 16'h0000, 3'b001);
        apply(7'b0010010, 10'd7, 16'h0000);
        @(negedge clk);
        check(6, 16'h0F0F, 3'b110);
        apply(7'b1111110, 10'd0, 16'h0000);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule